// File: doc/BRIEF.md
# Transport Packet Identifier and Section Filter

This block sits on a single transport stream input that delivers one 188-byte packet at a time, one byte per accepted cycle, with a marker on the first byte of every packet. It checks the sync byte and the error flag, extracts the 13-bit packet identifier and looks it up in a table of 48 programmable slots. Packets with no enabled match are discarded. A matching packet is tagged with the number of the slot that matched. It is then sent on one of two routes, depending on the slot. On the elementary-stream route every payload byte is forwarded unchanged. On the section route the section header at the start of a new section is compared with a bank of value/mask match filters.

The filter storage holds 768 value/mask byte pairs. It is read either as ninety-six filters of eight bytes or as forty-eight filters of sixteen bytes, selected by a mode input. The forwarded byte stream carries the slot number, the route, a running bitmap of filters that still match, and a pulse on the byte that closes the header window. A downstream stage uses these to steer bytes into circular buffers for decoders or into section buffers for software.

Top module: `ts_pid_section_filter`

## Requirements
- R1: One input byte is taken every cycle in which `in_valid` is high, with no stall. A forwarded byte appears on the outputs exactly one cycle after it was taken, and `out_valid` is never high unless `in_valid` was high in the cycle before.
- R2: A packet whose byte 0 is not 0x47, or whose byte 1 bit 7 (error flag) is set, forwards nothing.
- R3: The identifier is byte 1 bits 4:0 (upper bits) joined with byte 2. A packet forwards bytes only when an enabled slot holds that identifier. A slot write stores an enable, a 13-bit identifier and a route bit (0 = elementary stream, 1 = section). After reset every slot is disabled.
- R4: When several enabled slots hold the same identifier, the lowest-numbered one is used, and its number is shown on `out_slot`.
- R5: The payload-control field is byte 3 bits 5:4. With 01 the payload starts at byte 4. With 11, byte 4 holds an adaptation length L and the payload starts at byte 5+L. With 10 or 00 nothing is forwarded.
- R6: On the elementary-stream route every payload byte is forwarded with `out_route`=0, `out_hits` all zero and `out_hits_done` low.
- R7: On the section route, when byte 1 bit 6 (unit start) is set, the first payload byte is a pointer P and is not forwarded. The next P bytes are forwarded as continuation. The byte after them is byte 0 of a new section header. Without unit start, all payload bytes are continuation. A header window does not carry over into a following packet.
- R8: Filter storage address a holds a value/mask pair. In 8-byte mode, filter i compares header byte k (0..7) with address 8i+k. In 16-byte mode, filter j compares header byte k (0..15) with address 16j+k. A byte passes when ((data XOR value) AND mask) is zero. A filter's bit in `out_hits` stays set only while every header byte so far has passed.
- R9: `out_hits_done` is high on header byte 7 in 8-byte mode and on header byte 15 in 16-byte mode. Continuation bytes carry the last header bitmap produced, with `out_hits_done` low.
- R10: In 16-byte mode, filter j is reported on bit j of `out_hits` and bits 95:48 are zero.
- R11: `out_start` is high on the first forwarded byte of each packet only.
- R12: `in_start` restarts parsing at byte 0 at any point. Bytes beyond the 188th of a packet, without a new start, are ignored.
- R13: During and after reset `out_valid`, `out_hits` and `out_hits_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 selects 48 filters of 16 bytes, 0 selects 96 of 8 bytes |
| slot_wr_en | input | 1 | Slot table write strobe |
| slot_wr_idx | input | 6 | Slot number to write |
| slot_wr_valid | input | 1 | Enable bit written to the slot |
| slot_wr_pid | input | 13 | Identifier written to the slot |
| slot_wr_route | input | 1 | Route written to the slot (0 stream, 1 section) |
| flt_wr_en | input | 1 | Filter storage write strobe |
| flt_wr_addr | input | 10 | Filter storage byte address |
| flt_wr_value | input | 8 | Match value |
| flt_wr_mask | input | 8 | Match mask (1 = compared bit) |
| in_valid | input | 1 | Input byte present |
| in_start | input | 1 | Input byte is byte 0 of a packet |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Forwarded byte present |
| out_start | output | 1 | First forwarded byte of the packet |
| out_data | output | 8 | Forwarded byte |
| out_slot | output | 6 | Number of the slot that matched |
| out_route | output | 1 | 0 elementary stream, 1 section |
| out_hits | output | 96 | Running section filter bitmap |
| out_hits_done | output | 1 | Last header byte of the match window |

## Verification
Header comparison and continuation forwarding share the section path. With a nonzero pointer, one packet holds continuation bytes that must carry the held bitmap, followed at once by a fresh window. Packets with pointers 0 and 3, with an adaptation field ahead of the pointer, and with a corrupted header byte provoke this ordering. The bench model recomputes the bitmap from the stored packet bytes and compares it with the output on every clock. Slot priority and identifier lookup meet in the same cycle when two slots hold one identifier and the lower one is then disabled. The rerouted packet must then show the higher slot number and section tagging.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int unsigned PKT_LEN = 188;
  localparam logic [7:0]  SYNC_BYTE = 8'h47;
  localparam int unsigned PID_W = 13;

  typedef enum logic {
    ROUTE_ES  = 1'b0,
    ROUTE_SEC = 1'b1
  } route_e;
endpackage

// File: rtl/ts_pid_slots.sv
module ts_pid_slots #(
  parameter int unsigned NUM_SLOTS = 48,
  parameter int unsigned PID_W     = 13,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic              wr_valid,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic              wr_route,
  input  logic [PID_W-1:0]  lk_pid,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_idx,
  output logic              lk_route
);
  logic [NUM_SLOTS-1:0] en_q;
  logic [NUM_SLOTS-1:0] rt_q;
  logic [PID_W-1:0]     pid_q [NUM_SLOTS];

  logic wr_ok;
  assign wr_ok = wr_en && (int'(wr_idx) < NUM_SLOTS);

  // enable bits are reset; identifier and route are qualified by them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_ok) begin
      en_q[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      pid_q[wr_idx] <= wr_pid;
      rt_q[wr_idx]  <= wr_route;
    end
  end

  // scan from the top so the lowest matching slot is the last to land
  always_comb begin
    lk_hit   = 1'b0;
    lk_idx   = '0;
    lk_route = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (en_q[i] && (pid_q[i] == lk_pid)) begin
        lk_hit   = 1'b1;
        lk_idx   = SLOT_W'(i);
        lk_route = rt_q[i];
      end
    end
  end
endmodule

// File: rtl/ts_sec_match_bank.sv
module ts_sec_match_bank #(
  parameter int unsigned NUM_NARROW = 96,
  parameter int unsigned NARROW_LEN = 8,
  localparam int unsigned DEPTH  = NUM_NARROW * NARROW_LEN,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned IW     = $clog2(NARROW_LEN),
  localparam int unsigned KW     = IW + 1
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_value,
  input  logic [7:0]            wr_mask,
  input  logic                  wide,
  input  logic [KW-1:0]         byte_idx,
  input  logic [7:0]            byte_data,
  output logic [NUM_NARROW-1:0] byte_ok
);
  logic [7:0] val_q [DEPTH];
  logic [7:0] msk_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) begin
      val_q[wr_addr] <= wr_value;
      msk_q[wr_addr] <= wr_mask;
    end
  end

  // A 16-byte filter is an even/odd pair of 8-byte slices: the even slice
  // takes header bytes 0..7, the odd slice bytes 8..15.
  for (genvar i = 0; i < NUM_NARROW; i++) begin : g_slice
    localparam logic ODD = (i % 2) == 1;
    logic [ADDR_W-1:0] a;
    logic              act;
    always_comb begin
      a   = ADDR_W'(i * NARROW_LEN) + ADDR_W'(byte_idx[IW-1:0]);
      act = wide ? (byte_idx[KW-1] == ODD) : !byte_idx[KW-1];
      byte_ok[i] = !act || (((byte_data ^ val_q[a]) & msk_q[a]) == 8'h00);
    end
  end
endmodule

// File: rtl/ts_pid_section_filter.sv
module ts_pid_section_filter
  import tsf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 48,
  parameter int unsigned NUM_NARROW = 96,
  parameter int unsigned NARROW_LEN = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W = $clog2(NUM_NARROW * NARROW_LEN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wide,
  input  logic                  slot_wr_en,
  input  logic [SLOT_W-1:0]     slot_wr_idx,
  input  logic                  slot_wr_valid,
  input  logic [PID_W-1:0]      slot_wr_pid,
  input  logic                  slot_wr_route,
  input  logic                  flt_wr_en,
  input  logic [ADDR_W-1:0]     flt_wr_addr,
  input  logic [7:0]            flt_wr_value,
  input  logic [7:0]            flt_wr_mask,
  input  logic                  in_valid,
  input  logic                  in_start,
  input  logic [7:0]            in_data,
  output logic                  out_valid,
  output logic                  out_start,
  output logic [7:0]            out_data,
  output logic [SLOT_W-1:0]     out_slot,
  output logic                  out_route,
  output logic [NUM_NARROW-1:0] out_hits,
  output logic                  out_hits_done
);
  localparam int unsigned KW       = $clog2(NARROW_LEN) + 1;
  localparam int unsigned NUM_WIDE = NUM_NARROW / 2;
  localparam logic [8:0]  NO_PAY   = '1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [8:0]            cnt_q, cnt_d;
  logic                  sync_ok_q, sync_ok_d, tei_q, tei_d, pusi_q, pusi_d;
  logic [4:0]            pid_hi_q, pid_hi_d;
  logic                  hit_q, hit_d, route_q, route_d;
  logic [SLOT_W-1:0]     slot_q, slot_d;
  logic                  live_q, live_d, pl_first_q, pl_first_d;
  logic                  fwd_first_q, fwd_first_d;
  logic [8:0]            pay_ofs_q, pay_ofs_d;
  logic                  armed_q, armed_d, in_hdr_q, in_hdr_d;
  logic [7:0]            skip_q, skip_d;
  logic [KW-1:0]         k_q, k_d, kcur, win_last;
  logic [NUM_NARROW-1:0] hits_q, hits_d;
  logic                  o_valid_d, o_start_d, o_route_d, o_done_d;
  logic [7:0]            o_data_d;
  logic [SLOT_W-1:0]     o_slot_d;
  logic [NUM_NARROW-1:0] o_hits_d;

  logic [8:0]            idx;
  logic                  take, payload, sec_byte;
  logic                  lk_hit, lk_route;
  logic [SLOT_W-1:0]     lk_idx;
  logic [NUM_NARROW-1:0] byte_ok;

  function automatic logic [NUM_NARROW-1:0] fold(input logic [NUM_NARROW-1:0] v,
                                                 input logic w);
    fold = v;
    if (w) begin
      fold = '0;
      for (int j = 0; j < NUM_WIDE; j++) fold[j] = v[2*j] & v[2*j+1];
    end
  endfunction

  ts_pid_slots #(.NUM_SLOTS(NUM_SLOTS), .PID_W(PID_W)) u_slots (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(slot_wr_en), .wr_idx(slot_wr_idx), .wr_valid(slot_wr_valid),
    .wr_pid(slot_wr_pid), .wr_route(slot_wr_route),
    .lk_pid({pid_hi_q, in_data}), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_route(lk_route)
  );

  ts_sec_match_bank #(.NUM_NARROW(NUM_NARROW), .NARROW_LEN(NARROW_LEN)) u_bank (
    .clk(clk), .wr_en(flt_wr_en), .wr_addr(flt_wr_addr),
    .wr_value(flt_wr_value), .wr_mask(flt_wr_mask),
    .wide(cfg_wide), .byte_idx(kcur), .byte_data(in_data), .byte_ok(byte_ok)
  );

  assign idx      = in_start ? 9'd0 : cnt_q;
  assign take     = in_valid && (in_start || (cnt_q < 9'(PKT_LEN)));
  assign payload  = take && live_q && (idx >= 9'd4) && (idx >= pay_ofs_q);
  assign sec_byte = (armed_q && (skip_q == 8'd0)) || in_hdr_q;
  assign kcur     = armed_q ? '0 : k_q;
  assign win_last = cfg_wide ? KW'(2 * NARROW_LEN - 1) : KW'(NARROW_LEN - 1);

  always_comb begin
    cnt_d = cnt_q;  sync_ok_d = sync_ok_q;  tei_d = tei_q;  pusi_d = pusi_q;
    pid_hi_d = pid_hi_q;  hit_d = hit_q;  slot_d = slot_q;  route_d = route_q;
    live_d = live_q;  pl_first_d = pl_first_q;  fwd_first_d = fwd_first_q;
    pay_ofs_d = pay_ofs_q;  armed_d = armed_q;  in_hdr_d = in_hdr_q;
    skip_d = skip_q;  k_d = k_q;  hits_d = hits_q;
    o_valid_d = 1'b0;  o_start_d = 1'b0;  o_done_d = 1'b0;
    o_data_d = out_data;  o_slot_d = out_slot;  o_route_d = out_route;
    o_hits_d = out_hits;
    if (take) begin
      cnt_d = idx + 9'd1;
      if (in_start) begin
        live_d = 1'b0;  fwd_first_d = 1'b1;  pay_ofs_d = NO_PAY;
        armed_d = 1'b0;  in_hdr_d = 1'b0;
      end
      case (idx)
        9'd0: sync_ok_d = (in_data == SYNC_BYTE);
        9'd1: begin
          tei_d = in_data[7];  pusi_d = in_data[6];  pid_hi_d = in_data[4:0];
        end
        9'd2: begin
          hit_d = lk_hit;  slot_d = lk_idx;  route_d = lk_route;
        end
        9'd3: begin
          live_d     = sync_ok_q && !tei_q && hit_q && in_data[4];
          pay_ofs_d  = in_data[5] ? NO_PAY : 9'd4;
          pl_first_d = 1'b1;
        end
        9'd4: if (pay_ofs_q == NO_PAY) pay_ofs_d = 9'd5 + {1'b0, in_data};
        default: ;
      endcase
    end
    if (payload) begin
      pl_first_d = 1'b0;
      if (route_q == ROUTE_SEC && pl_first_q && pusi_q) begin
        armed_d = 1'b1;          // pointer byte: consumed, not forwarded
        skip_d  = in_data;
      end else begin
        o_valid_d   = 1'b1;
        o_start_d   = fwd_first_q;
        fwd_first_d = 1'b0;
        o_data_d    = in_data;
        o_slot_d    = slot_q;
        o_route_d   = route_q;
        o_hits_d    = '0;
        if (route_q == ROUTE_SEC) begin
          if (armed_q && skip_q != 8'd0) skip_d = skip_q - 8'd1;
          if (sec_byte) begin
            hits_d   = (armed_q ? '1 : hits_q) & byte_ok;
            armed_d  = 1'b0;
            in_hdr_d = (kcur != win_last);
            k_d      = kcur + KW'(1);
            o_done_d = (kcur == win_last);
            o_hits_d = fold(hits_d, cfg_wide);
          end else begin
            o_hits_d = fold(hits_q, cfg_wide);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cnt_q <= 9'(PKT_LEN);  sync_ok_q <= 1'b0;  tei_q <= 1'b0;  pusi_q <= 1'b0;
      pid_hi_q <= '0;  hit_q <= 1'b0;  slot_q <= '0;  route_q <= 1'b0;
      live_q <= 1'b0;  pl_first_q <= 1'b0;  fwd_first_q <= 1'b0;
      pay_ofs_q <= NO_PAY;  armed_q <= 1'b0;  in_hdr_q <= 1'b0;
      skip_q <= '0;  k_q <= '0;  hits_q <= '0;
      out_valid <= 1'b0;  out_start <= 1'b0;  out_data <= '0;  out_slot <= '0;
      out_route <= 1'b0;  out_hits <= '0;  out_hits_done <= 1'b0;
    end else begin
      cnt_q <= cnt_d;  sync_ok_q <= sync_ok_d;  tei_q <= tei_d;  pusi_q <= pusi_d;
      pid_hi_q <= pid_hi_d;  hit_q <= hit_d;  slot_q <= slot_d;  route_q <= route_d;
      live_q <= live_d;  pl_first_q <= pl_first_d;  fwd_first_q <= fwd_first_d;
      pay_ofs_q <= pay_ofs_d;  armed_q <= armed_d;  in_hdr_q <= in_hdr_d;
      skip_q <= skip_d;  k_q <= k_d;  hits_q <= hits_d;
      out_valid <= o_valid_d;  out_start <= o_start_d;  out_data <= o_data_d;
      out_slot <= o_slot_d;  out_route <= o_route_d;  out_hits <= o_hits_d;
      out_hits_done <= o_done_d;
    end
  end
endmodule

// File: rtl/tsf_checks.sv
module tsf_checks #(
  parameter int unsigned NUM_SLOTS  = 48,
  parameter int unsigned NUM_NARROW = 96,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_wide,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic                  out_start,
  input logic [SLOT_W-1:0]     out_slot,
  input logic                  out_route,
  input logic [NUM_NARROW-1:0] out_hits,
  input logic                  out_hits_done
);
  p_out_after_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_es_no_bitmap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_route) |-> (out_hits == '0 && !out_hits_done));

  p_done_on_section_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_hits_done |-> (out_valid && out_route));

  p_wide_upper_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_wide)) |-> (out_hits[NUM_NARROW-1:NUM_NARROW/2] == '0));

  p_slot_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_slot) < NUM_SLOTS));

  p_start_with_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);
endmodule

bind ts_pid_section_filter tsf_checks #(.NUM_SLOTS(NUM_SLOTS), .NUM_NARROW(NUM_NARROW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .in_valid(in_valid),
  .out_valid(out_valid), .out_start(out_start), .out_slot(out_slot),
  .out_route(out_route), .out_hits(out_hits), .out_hits_done(out_hits_done)
);

// File: tb/ts_pid_section_filter_test.sv
`timescale 1ns/1ps
module ts_pid_section_filter_test;
  localparam int NS = 48, NF = 96, DEPTH = 768;

  logic clk, rst_n, cfg_wide;
  logic slot_wr_en, slot_wr_valid, slot_wr_route;
  logic [5:0] slot_wr_idx;
  logic [12:0] slot_wr_pid;
  logic flt_wr_en;
  logic [9:0] flt_wr_addr;
  logic [7:0] flt_wr_value, flt_wr_mask;
  logic in_valid, in_start;
  logic [7:0] in_data;
  logic out_valid, out_start, out_route, out_hits_done;
  logic [7:0] out_data;
  logic [5:0] out_slot;
  logic [95:0] out_hits;

  ts_pid_section_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
    .slot_wr_en(slot_wr_en), .slot_wr_idx(slot_wr_idx), .slot_wr_valid(slot_wr_valid),
    .slot_wr_pid(slot_wr_pid), .slot_wr_route(slot_wr_route),
    .flt_wr_en(flt_wr_en), .flt_wr_addr(flt_wr_addr), .flt_wr_value(flt_wr_value),
    .flt_wr_mask(flt_wr_mask), .in_valid(in_valid), .in_start(in_start),
    .in_data(in_data), .out_valid(out_valid), .out_start(out_start),
    .out_data(out_data), .out_slot(out_slot), .out_route(out_route),
    .out_hits(out_hits), .out_hits_done(out_hits_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  string cur_req = "R13";

  // behavioural model state
  bit          m_sv [NS];
  int          m_sp [NS];
  bit          m_sr [NS];
  logic [7:0]  m_fv [DEPTH];
  logic [7:0]  m_fm [DEPTH];
  bit          m_wide = 0;
  logic [7:0]  pk [188];
  int          m_cnt = 188;
  bit          m_started = 0;
  logic [95:0] m_hits = '0;
  logic [7:0]  tx [188];

  bit e_v, e_s, e_route, e_done;
  logic [7:0] e_d;
  int e_slot;
  logic [95:0] e_hits;

  function automatic logic [7:0] hdr_byte(int k);
    return 8'h40 + 8'(k * 7);
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL R1 watchdog: cycles=%0d expected below 150000", cyc);
      report();
      $finish;
    end
  end

  task automatic model_byte(input bit st, input logic [7:0] d);
    int n, ps, s, slot, afc, k, w;
    logic [12:0] pid;
    bit h;
    e_v = 0; e_s = 0; e_route = 0; e_done = 0; e_d = 0; e_slot = 0; e_hits = '0;
    if (!st && m_cnt >= 188) return;                   // R12 surplus ignored
    n = st ? 0 : m_cnt;
    if (st) m_started = 0;
    pk[n] = d; m_cnt = n + 1;
    if (n < 4) return;
    if (pk[0] != 8'h47 || pk[1][7]) return;            // R2
    pid = {pk[1][4:0], pk[2]};
    slot = -1;
    for (int i = 0; i < NS; i++)
      if (slot < 0 && m_sv[i] && m_sp[i] == int'(pid)) slot = i;
    if (slot < 0) return;                              // R3
    afc = int'(pk[3][5:4]);
    if (afc == 0 || afc == 2) return;                  // R5
    if (afc == 1) ps = 4;
    else begin
      if (n == 4) return;
      ps = 5 + int'(pk[4]);
    end
    if (n < ps) return;
    s = -1000;
    if (m_sr[slot] && pk[1][6]) begin
      if (n == ps) return;                             // R7 pointer
      s = ps + 1 + int'(pk[ps]);
    end
    e_v = 1; e_s = !m_started; m_started = 1;
    e_d = d; e_slot = slot; e_route = m_sr[slot];
    if (!m_sr[slot]) return;                           // R6
    w = m_wide ? 16 : 8;
    k = n - s;
    if (k >= 0 && k < w) begin                         // R8
      m_hits = '0;
      for (int f = 0; f < (m_wide ? NF / 2 : NF); f++) begin
        h = 1;
        for (int kk = 0; kk <= k; kk++) begin
          int a;
          a = f * w + kk;
          if (((pk[s+kk] ^ m_fv[a]) & m_fm[a]) != 8'h00) h = 0;
        end
        m_hits[f] = h;
      end
      e_done = (k == w - 1);                           // R9
    end
    e_hits = m_hits;
  endtask

  task automatic check();
    bit bad;
    n_chk++;
    bad = (out_valid !== e_v);
    if (e_v)
      bad = bad || out_start !== e_s || out_data !== e_d || int'(out_slot) != e_slot ||
            out_route !== e_route || out_hits !== e_hits || out_hits_done !== e_done;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got v=%0b st=%0b d=%h slot=%0d rt=%0b hits=%h done=%0b; expected v=%0b st=%0b d=%h slot=%0d rt=%0b hits=%h done=%0b",
               cur_req, out_valid, out_start, out_data, out_slot, out_route, out_hits,
               out_hits_done, e_v, e_s, e_d, e_slot, e_route, e_hits, e_done);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check();
    in_valid = 0; in_start = 0; slot_wr_en = 0; flt_wr_en = 0;
    e_v = 0;
  endtask

  task automatic send_byte(input bit st, input logic [7:0] d);
    tick();
    in_valid = 1; in_start = st; in_data = d;
    model_byte(st, d);
  endtask

  task automatic wr_slot(input int i, input bit v, input int pid, input bit rt);
    tick();
    slot_wr_en = 1; slot_wr_idx = 6'(i); slot_wr_valid = v;
    slot_wr_pid = 13'(pid); slot_wr_route = rt;
    m_sv[i] = v; m_sp[i] = pid; m_sr[i] = rt;
  endtask

  task automatic wr_flt(input int a, input logic [7:0] v, input logic [7:0] m);
    tick();
    flt_wr_en = 1; flt_wr_addr = 10'(a); flt_wr_value = v; flt_wr_mask = m;
    m_fv[a] = v; m_fm[a] = m;
  endtask

  task automatic build(input logic [7:0] sync, input bit tei, input bit pusi,
                       input int pid, input int afc, input int aflen, input int ptr,
                       input int corrupt, input int seed);
    int ps, s, r;
    r = seed;
    for (int i = 0; i < 188; i++) begin
      r = (r * 1103515245 + 12345) & 32'h7fffffff;
      tx[i] = 8'(r >> 16);
    end
    tx[0] = sync;
    tx[1] = {tei, pusi, 1'b0, 5'(pid >> 8)};
    tx[2] = 8'(pid);
    tx[3] = {2'b00, 2'(afc), 4'h0};
    if (afc == 3) tx[4] = 8'(aflen);
    ps = (afc == 3) ? 5 + aflen : 4;
    if (pusi) begin
      tx[ps] = 8'(ptr);
      s = ps + 1 + ptr;
      for (int k = 0; k < 16; k++)
        if (s + k < 188) tx[s+k] = hdr_byte(k) ^ ((k == corrupt) ? 8'hFF : 8'h00);
    end
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) send_byte(i == 0, tx[i % 188]);
  endtask

  initial begin
    rst_n = 0; cfg_wide = 0; in_valid = 0; in_start = 0; in_data = 0;
    slot_wr_en = 0; slot_wr_idx = 0; slot_wr_valid = 0; slot_wr_pid = 0;
    slot_wr_route = 0; flt_wr_en = 0; flt_wr_addr = 0; flt_wr_value = 0;
    flt_wr_mask = 0;
    e_v = 0; e_s = 0; e_route = 0; e_done = 0; e_d = 0; e_slot = 0; e_hits = '0;
    for (int i = 0; i < NS; i++) begin m_sv[i] = 0; m_sp[i] = 0; m_sr[i] = 0; end
    repeat (4) @(negedge clk);
    // R13: outputs quiet in reset
    n_chk++;
    if (out_valid !== 1'b0 || out_hits !== '0 || out_hits_done !== 1'b0) begin
      n_bad++;
      $display("FAIL R13: v=%0b hits=%h done=%0b expected 0 0 0", out_valid, out_hits, out_hits_done);
    end
    rst_n = 1;
    repeat (4) tick();

    // R3: all slots disabled after reset, so nothing forwarded
    cur_req = "R3 R13";
    build(8'h47, 0, 0, 13'h100, 1, 0, 0, -1, 11); send(188);

    // filter storage: mixed exact, wildcard, masked and offset patterns
    for (int a = 0; a < DEPTH; a++) begin
      int f, b;
      f = a / 8; b = a % 8;
      case (f % 8)
        0, 4: wr_flt(a, hdr_byte(b), 8'hFF);
        1, 5: wr_flt(a, 8'h00, 8'h00);
        2:    wr_flt(a, hdr_byte(b) ^ ((b == 5) ? 8'h01 : 8'h00), 8'hFF);
        6:    wr_flt(a, hdr_byte(b) ^ ((b == 5) ? 8'h01 : 8'h00), 8'hFE);
        default: wr_flt(a, hdr_byte(b + 8), 8'hF0);
      endcase
    end
    wr_slot(3, 1, 13'h100, 0);
    wr_slot(5, 1, 13'h100, 1);
    wr_slot(7, 1, 13'h0ABC, 1);
    wr_slot(10, 1, 13'h0123, 0);
    wr_slot(47, 1, 13'h1FFF, 1);
    wr_slot(0, 0, 13'h0555, 0);

    cur_req = "R4 R6 R11"; build(8'h47, 0, 0, 13'h100, 1, 0, 0, -1, 21); send(188);
    cur_req = "R2";        build(8'h46, 0, 0, 13'h100, 1, 0, 0, -1, 22); send(188);
    cur_req = "R2";        build(8'h47, 1, 0, 13'h100, 1, 0, 0, -1, 23); send(188);
    cur_req = "R3";        build(8'h47, 0, 0, 13'h0555, 1, 0, 0, -1, 24); send(188);
    cur_req = "R5 R6";     build(8'h47, 0, 0, 13'h0123, 3, 10, 0, -1, 25); send(188);
    cur_req = "R5";        build(8'h47, 0, 0, 13'h0123, 2, 10, 0, -1, 26); send(188);
    cur_req = "R5";        build(8'h47, 0, 0, 13'h0123, 0, 0, 0, -1, 27); send(188);
    cur_req = "R7 R8 R9";  build(8'h47, 0, 1, 13'h0ABC, 1, 0, 0, -1, 31); send(188);
    cur_req = "R7 R8 R9";  build(8'h47, 0, 1, 13'h0ABC, 1, 0, 3, 2, 32); send(188);
    cur_req = "R7 R9";     build(8'h47, 0, 0, 13'h0ABC, 1, 0, 0, -1, 33); send(188);
    cur_req = "R5 R7 R8";  build(8'h47, 0, 1, 13'h1FFF, 3, 6, 2, 6, 34); send(188);
    // R12: restart mid-packet, then surplus bytes after 188
    cur_req = "R12";       build(8'h47, 0, 0, 13'h100, 1, 0, 0, -1, 41); send(90);
    cur_req = "R12";       build(8'h47, 0, 0, 13'h0123, 1, 0, 0, -1, 42); send(193);
    // R4: drop the lower duplicate, higher slot takes over with section route
    wr_slot(3, 0, 13'h100, 0);
    cur_req = "R4 R7";     build(8'h47, 0, 1, 13'h100, 1, 0, 1, -1, 43); send(188);
    // R10: 16-byte filters
    tick(); cfg_wide = 1; m_wide = 1;
    cur_req = "R8 R9 R10"; build(8'h47, 0, 1, 13'h0ABC, 1, 0, 0, -1, 51); send(188);
    cur_req = "R8 R10";    build(8'h47, 0, 1, 13'h0ABC, 1, 0, 4, 12, 52); send(188);
    cur_req = "R1 R11";    build(8'h47, 0, 0, 13'h0123, 1, 0, 0, -1, 53); send(188);
    repeat (4) tick();
    finished = 1;
    report();
    $finish;
  end
endmodule